// File: doc/BRIEF.md
# Status Register Write Guard

This block decides the fate of every write aimed at a device status register. The command decoder reports three things: that a write-status opcode has arrived, that the data byte is complete, and the byte itself. The block also watches the chip-select level and an external active-low protect pin. Using these and the protect-enable bit held inside the status register, it commits, aborts or inhibits each write. A committed write runs a timed internal write cycle. A busy flag stays high for the whole cycle, and the new value lands in the register when the cycle ends.

The block also holds the write-enable latch. A status write is accepted only while this latch is set, and the latch clears itself when a write cycle finishes. The protect pin takes effect only when the protect-enable bit (bit 7 of the status register) is 1. Once the internal cycle has started, the pin can no longer stop it. Serial shifting and the memory array sit outside this block.

Top module: `sr_guard`

## Requirements
- R1: After reset the status register reads 0x00, and busy and the write-enable latch are both 0.
- R2: A pulse on wel_set sets the write-enable latch and a pulse on wel_clr clears it (set wins if both are high). While busy is high, both pulses are ignored.
- R3: A status write requested while the write-enable latch is 0 changes nothing: busy stays 0 and the register keeps its value.
- R4: With the protect pin high, a write request, a complete byte and then chip-select high commit the write.
- R5: If bit 7 of the status register is 1 and the protect pin is low when the request arrives, the write is inhibited. Busy stays 0, the register is unchanged and the latch keeps its value.
- R6: If bit 7 of the status register is 0, the protect pin has no effect on any status write.
- R7: If bit 7 is 1 and the protect pin goes low while chip select is still low after an accepted request, the write is aborted. Busy stays 0, the register is unchanged and the latch stays set.
- R8: The write cycle starts only when chip select goes high after a complete data byte. If chip select goes high before the byte arrives, the request is dropped and a later byte has no effect.
- R9: Busy rises on the first clock after chip select is seen high and stays high for exactly WR_CYCLES clocks. When it falls, the register takes the new value and the latch clears in the same clock.
- R10: A change on the protect pin during the write cycle does not stop that write.
- R11: Write requests, bytes and chip-select edges that arrive while busy is high are ignored.
- R12: Only the bits set in WR_MASK (default 0x8C: bits 7, 3 and 2) can be written. All other bits stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip-select level, low = selected |
| prot_n | input | 1 | External write-protect pin, low = protect |
| wel_set | input | 1 | Decoder pulse: set write-enable latch |
| wel_clr | input | 1 | Decoder pulse: clear write-enable latch |
| stw_start | input | 1 | Decoder pulse: write-status opcode received |
| stw_byte_vld | input | 1 | Decoder pulse: full data byte on stw_data |
| stw_data | input | DATA_W | Data byte of the status write |
| sreg_q | output | DATA_W | Current status register value |
| busy | output | 1 | Internal write cycle in progress |
| wel | output | 1 | Write-enable latch |

## Verification
A sequencer stuck in an accepting state would let a protected write through. That shows as busy going high on the clock after chip select rises, even though it should have stayed low. A timer loaded with the wrong value shows as busy falling one or more clocks too early or too late. The register update comes in that same clock, so a register committed early or late is also visible at once on sreg_q. A latch that is not cleared when a cycle ends shows up as wel still high right after busy falls.

// File: rtl/sr_guard_pkg.sv
package sr_guard_pkg;

    typedef enum logic [1:0] {
        SG_IDLE   = 2'd0,
        SG_ARMED  = 2'd1,
        SG_LOADED = 2'd2
    } sg_state_e;

    // Protection is live only when the enable bit is set and the pin is low
    function automatic logic prot_active(input logic wpen, input logic prot_n);
        return wpen & ~prot_n;
    endfunction

endpackage

// File: rtl/sr_wel_latch.sv
module sr_wel_latch (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    input  logic busy_i,
    input  logic done_i,
    output logic wel_o
);
    logic wel_q;

    always_ff @(posedge clk) begin
        if (rst)
            wel_q <= 1'b0;
        else if (done_i)
            wel_q <= 1'b0;
        else if (!busy_i) begin
            if (set_i)
                wel_q <= 1'b1;
            else if (clr_i)
                wel_q <= 1'b0;
        end
    end

    assign wel_o = wel_q;

    AST_WEL_CLR_AT_DONE: assert property (@(posedge clk) disable iff (rst)
        done_i |=> !wel_q); // R9
    AST_WEL_FROZEN_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy_i && !done_i) |=> $stable(wel_q)); // R2

endmodule

// File: rtl/sr_wr_timer.sv
module sr_wr_timer #(
    parameter int WR_CYCLES = 10000
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);
    localparam int CNT_W = $clog2(WR_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;

    assign done_o = busy_q && (cnt_q == '0);
    assign busy_o = busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start_i && !busy_q) begin
            busy_q <= 1'b1;
            cnt_q  <= CNT_W'(WR_CYCLES - 1);
        end else if (busy_q) begin
            if (cnt_q == '0)
                busy_q <= 1'b0;
            else
                cnt_q <= cnt_q - 1'b1;
        end
    end

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (busy_q && cnt_q != '0) |=> busy_q); // R9
    AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !busy_q); // R9
    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        start_i |-> !busy_q); // R11

endmodule

// File: rtl/sr_wr_seq.sv
module sr_wr_seq
    import sr_guard_pkg::*;
#(
    parameter int                DATA_W   = 8,
    parameter int                WPEN_BIT = 7,
    parameter logic [DATA_W-1:0] WR_MASK  = 8'h8C
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              prot_n,
    input  logic              stw_start,
    input  logic              stw_byte_vld,
    input  logic [DATA_W-1:0] stw_data,
    input  logic              wel_i,
    input  logic              busy_i,
    input  logic              done_i,
    output logic              start_o,
    output logic [DATA_W-1:0] sreg_o
);
    sg_state_e         state_q, state_d;
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] sreg_q;
    logic              prot_act;
    logic              take_byte;

    assign prot_act = prot_active(sreg_q[WPEN_BIT], prot_n);
    assign start_o  = (state_q == SG_LOADED) && cs_n;
    assign take_byte = (state_q == SG_ARMED) && !cs_n && !prot_act && stw_byte_vld;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SG_IDLE: begin
                if (stw_start && !cs_n && !busy_i && wel_i && !prot_act)
                    state_d = SG_ARMED;
            end
            SG_ARMED: begin
                if (cs_n || prot_act)
                    state_d = SG_IDLE;
                else if (stw_byte_vld)
                    state_d = SG_LOADED;
            end
            SG_LOADED: begin
                if (cs_n || prot_act)
                    state_d = SG_IDLE;
            end
            default: state_d = SG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SG_IDLE;
            data_q  <= '0;
            sreg_q  <= '0;
        end else begin
            state_q <= state_d;
            if (take_byte)
                data_q <= stw_data;
            if (done_i)
                sreg_q <= (sreg_q & ~WR_MASK) | (data_q & WR_MASK);
        end
    end

    assign sreg_o = sreg_q;

    AST_ARMED_HAS_WEL: assert property (@(posedge clk) disable iff (rst)
        (state_q != SG_IDLE) |-> wel_i); // R3
    AST_ABORT_ON_PROT: assert property (@(posedge clk) disable iff (rst)
        (state_q != SG_IDLE && !cs_n && prot_act) |=> (state_q == SG_IDLE)); // R7
    AST_SREG_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        !done_i |=> $stable(sreg_q)); // R10
    AST_RO_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
        ((sreg_q & ~WR_MASK) == '0)); // R12
    AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy_i |-> (state_q == SG_IDLE)); // R11

endmodule

// File: rtl/sr_guard.sv
module sr_guard
    import sr_guard_pkg::*;
#(
    parameter int                DATA_W    = 8,
    parameter int                WPEN_BIT  = 7,
    parameter logic [DATA_W-1:0] WR_MASK   = 8'h8C,
    parameter int                WR_CYCLES = 10000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              prot_n,
    input  logic              wel_set,
    input  logic              wel_clr,
    input  logic              stw_start,
    input  logic              stw_byte_vld,
    input  logic [DATA_W-1:0] stw_data,
    output logic [DATA_W-1:0] sreg_q,
    output logic              busy,
    output logic              wel
);
    logic start_w;
    logic busy_w;
    logic done_w;
    logic wel_w;

    sr_wel_latch u_wel (
        .clk    (clk),
        .rst    (rst),
        .set_i  (wel_set),
        .clr_i  (wel_clr),
        .busy_i (busy_w),
        .done_i (done_w),
        .wel_o  (wel_w)
    );

    sr_wr_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_w),
        .busy_o  (busy_w),
        .done_o  (done_w)
    );

    sr_wr_seq #(
        .DATA_W   (DATA_W),
        .WPEN_BIT (WPEN_BIT),
        .WR_MASK  (WR_MASK)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .cs_n         (cs_n),
        .prot_n       (prot_n),
        .stw_start    (stw_start),
        .stw_byte_vld (stw_byte_vld),
        .stw_data     (stw_data),
        .wel_i        (wel_w),
        .busy_i       (busy_w),
        .done_i       (done_w),
        .start_o      (start_w),
        .sreg_o       (sreg_q)
    );

    assign busy = busy_w;
    assign wel  = wel_w;

endmodule

// File: tb/sim_sr_guard.sv
module sim_sr_guard;
    localparam int CLK_PERIOD = 10;
    localparam int WRC        = 12;
    localparam int NVEC       = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1;
    logic       prot_n = 1'b1;
    logic       wel_set = 1'b0;
    logic       wel_clr = 1'b0;
    logic       stw_start = 1'b0;
    logic       stw_byte_vld = 1'b0;
    logic [7:0] stw_data = '0;
    logic [7:0] sreg_q;
    logic       busy;
    logic       wel;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sr_guard #(.WR_CYCLES(WRC)) u0 (
        .clk(clk), .rst(rst), .cs_n(cs_n), .prot_n(prot_n),
        .wel_set(wel_set), .wel_clr(wel_clr), .stw_start(stw_start),
        .stw_byte_vld(stw_byte_vld), .stw_data(stw_data),
        .sreg_q(sreg_q), .busy(busy), .wel(wel)
    );

    // {wpen_init, prot_n, set_wel, drop_prot, data[7:0], exp_sreg[7:0], commit}
    localparam logic [20:0] VEC [NVEC] = '{
        {1'b0, 1'b1, 1'b1, 1'b0, 8'h0C, 8'h0C, 1'b1},  // R4
        {1'b0, 1'b0, 1'b1, 1'b0, 8'h84, 8'h84, 1'b1},  // R6
        {1'b1, 1'b0, 1'b1, 1'b0, 8'h0C, 8'h80, 1'b0},  // R5
        {1'b1, 1'b1, 1'b1, 1'b0, 8'h0C, 8'h0C, 1'b1},  // R4
        {1'b0, 1'b1, 1'b0, 1'b0, 8'h8C, 8'h00, 1'b0},  // R3
        {1'b1, 1'b1, 1'b1, 1'b1, 8'h0C, 8'h80, 1'b0},  // R7
        {1'b0, 1'b1, 1'b1, 1'b1, 8'h8C, 8'h8C, 1'b1},  // R6
        {1'b0, 1'b1, 1'b1, 1'b0, 8'hFF, 8'h8C, 1'b1}   // R12
    };

    task automatic step();
        @(negedge clk);
    endtask

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; cs_n = 1'b1; prot_n = 1'b1;
        wel_set = 0; wel_clr = 0; stw_start = 0; stw_byte_vld = 0;
        step(); step();
        rst = 1'b0;
        step();
    endtask

    task automatic pulse_wel();
        wel_set = 1'b1; step(); wel_set = 1'b0;
    endtask

    // Request, byte, optional protect drop with CS low, then deselect
    task automatic do_write(input logic [7:0] d, input logic drop);
        cs_n = 1'b0; stw_start = 1'b1; step();
        stw_start = 1'b0; stw_byte_vld = 1'b1; stw_data = d; step();
        stw_byte_vld = 1'b0;
        if (drop) begin prot_n = 1'b0; step(); end
        cs_n = 1'b1; step();
    endtask

    task automatic wait_out();
        repeat (WRC + 2) step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung run, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        step();
        do_reset();
        check(sreg_q == 8'h00, "R1 sreg", sreg_q, 0);
        check(busy == 1'b0, "R1 busy", busy, 0);
        check(wel == 1'b0, "R1 wel", wel, 0);

        for (int i = 0; i < NVEC; i++) begin
            logic [20:0] v;
            v = VEC[i];
            do_reset();
            if (v[20]) begin
                pulse_wel();
                do_write(8'h80, 1'b0);
                wait_out();
            end
            prot_n = v[19];
            if (v[18]) pulse_wel();
            do_write(v[16:9], v[17]);
            check(busy == v[0], "R4/R5/R7 busy after deselect", busy, v[0]);
            prot_n = 1'b1;
            wait_out();
            check(sreg_q == v[8:1], "R4/R6/R12 sreg result", sreg_q, v[8:1]);
            check(wel == (v[0] ? 1'b0 : v[18]), "R9/R7 wel after", wel, v[0] ? 0 : v[18]);
        end

        // R9: exact busy length and commit at its end
        do_reset();
        pulse_wel();
        do_write(8'h0C, 1'b0);
        check(busy == 1'b1, "R9 busy first clock", busy, 1);
        repeat (WRC - 1) step();
        check(busy == 1'b1 && sreg_q == 8'h00, "R9 busy last clock", {busy, sreg_q}, 9'h100);
        step();
        check(busy == 1'b0, "R9 busy falls", busy, 0);
        check(sreg_q == 8'h0C, "R9 sreg at fall", sreg_q, 8'h0C);
        check(wel == 1'b0, "R9 wel at fall", wel, 0);

        // R10: protect during write cycle with enable set
        do_reset();
        pulse_wel(); do_write(8'h80, 1'b0); wait_out();
        pulse_wel(); do_write(8'h04, 1'b0);
        prot_n = 1'b0;
        wait_out();
        check(sreg_q == 8'h04, "R10 write survives protect", sreg_q, 8'h04);
        prot_n = 1'b1;

        // R11 and R2: activity during busy ignored
        do_reset();
        pulse_wel(); do_write(8'h0C, 1'b0);
        wel_clr = 1'b1; step(); wel_clr = 1'b0;
        check(wel == 1'b1, "R2 clr ignored while busy", wel, 1);
        do_write(8'h80, 1'b0);
        wait_out();
        check(sreg_q == 8'h0C, "R11 request during busy", sreg_q, 8'h0C);
        check(busy == 1'b0, "R11 no second cycle", busy, 0);
        wel_set = 1'b1; step(); wel_set = 1'b0;
        check(wel == 1'b1, "R2 set after idle", wel, 1);

        // R8: deselect before byte drops the request
        do_reset();
        pulse_wel();
        cs_n = 1'b0; stw_start = 1'b1; step(); stw_start = 1'b0;
        cs_n = 1'b1; step(); step();
        check(busy == 1'b0, "R8 early deselect", busy, 0);
        stw_byte_vld = 1'b1; stw_data = 8'h8C; step(); stw_byte_vld = 1'b0;
        cs_n = 1'b0; step(); cs_n = 1'b1; step(); step();
        check(busy == 1'b0 && sreg_q == 8'h00, "R8 late byte ignored", {busy, sreg_q}, 0);
        check(wel == 1'b1, "R8 wel kept", wel, 1);

        // R2: clear pulse then write needs latch
        wel_clr = 1'b1; step(); wel_clr = 1'b0;
        check(wel == 1'b0, "R2 clear", wel, 0);
        do_write(8'h0C, 1'b0);
        check(busy == 1'b0, "R3 no latch no cycle", busy, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule